// File: doc/BRIEF.md
# Dual Reload Timer/Counter

This block holds two 16-bit timers. Each timer is stored as a low byte and a high byte, and both timers advance on a single shared prescaled tick. Each timer has a 2-bit mode field that selects one of four modes:

- 16-bit counting with reload from a dedicated pair of reload bytes.
- Plain 16-bit wrap-around counting.
- 8-bit counting on the low byte with reload from the low reload byte.
- A special mode that differs by timer. It freezes timer 1. It splits timer 0 into two independent 8-bit counters, and the upper one takes over timer 1's run bit and overflow flag.

Software accesses every register as a byte through a single write port and a combinational read port. Each overflow flag also serves as an interrupt request. An acknowledge input clears the flag. A one-cycle overflow pulse per timer feeds a baud-rate consumer. Each timer has a gate input that can make counting depend on an external level.

Top module: `dual_reload_timer`

## Requirements
- R1: After reset every register reads 00h, both interrupt outputs and both pulse outputs are low, and the prescaler divides by 4.
- R2: Configuration byte (address 2) bits [1:0] select the prescale divisor N: code 0 gives 4, code 1 gives 16, codes 2 and 3 give 64. A running timer advances exactly once every N clocks.
- R3: In mode 0 the 16-bit count climbs. At FFFFh the next tick sets the flag, loads the low byte from the low reload byte (timer 0 at address 6, timer 1 at address 10) and loads the high byte from the high reload byte (addresses 7 and 11), all in one cycle.
- R4: In mode 1 the 16-bit count wraps from FFFFh to 0000h and sets the flag. The reload bytes are ignored.
- R5: In mode 2 only the low byte counts. On FFh the next tick sets the flag and loads the low reload byte. The high byte keeps its value.
- R6: Timer 1 in mode 3 holds its count while its run bit is set, and produces no overflow pulse.
- R7: Timer 0 in mode 3 counts its low byte (8-bit wrap to 00h) under the timer 0 run bit, gate and flag. Its high byte counts prescaled ticks under the timer 1 run bit, wraps at FFh and sets the timer 1 flag.
- R8: The control byte (address 0) holds timer 1 flag at bit 7, timer 1 run at bit 6, timer 0 flag at bit 5 and timer 0 run at bit 4. Bits 3:0 read 0.
- R9: An overflow flag is cleared by its acknowledge input or by writing 0. An overflow in the same cycle as an acknowledge or as a software write leaves the flag set.
- R10: While a timer's toggle-output enable (configuration byte bit 2 for timer 0, bit 3 for timer 1) is 1, its overflows do not set its flag. The overflow pulse still occurs.
- R11: A timer's overflow pulse is high for the one cycle after each overflow. While timer 0 is in mode 3, timer 1 in modes 0 to 2 counts without its run bit and pulses on overflow, but does not set the timer 1 flag.
- R12: Mode byte (address 1) layout: bits [1:0] timer 0 mode, bit 2 timer 0 gate, bits [5:4] timer 1 mode, bit 6 timer 1 gate. With the gate bit at 1 a timer counts only while its gate input is high.
- R13: Count bytes (timer 0 low/high at 4 and 5, timer 1 at 8 and 9), reload bytes, mode byte and configuration byte read back what was written. Unused addresses read 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe |
| addr | input | 4 | Register address for reads and writes |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data for addr |
| gate0_in | input | 1 | External gate level for timer 0 |
| gate1_in | input | 1 | External gate level for timer 1 |
| ack0 | input | 1 | Interrupt acknowledge, clears timer 0 flag |
| ack1 | input | 1 | Interrupt acknowledge, clears timer 1 flag |
| irq0 | output | 1 | Timer 0 overflow flag |
| irq1 | output | 1 | Timer 1 overflow flag |
| ovf_pulse0 | output | 1 | One-cycle timer 0 overflow pulse |
| ovf_pulse1 | output | 1 | One-cycle timer 1 overflow pulse |

## Verification
The bench uses the default divisors of 4, 16 and 64. It runs each timer for an exact multiple of N clocks, so the increment count does not depend on the phase of the free-running prescaler. At divisor 4 it sweeps both timers through modes 0 to 2. Each run uses four reload values close to the top of the range and 1 to 12 ticks, so every wrap and reload position near overflow is reached. Expected counts, flags and pulse totals come from stepping the arithmetic in the bench. The coincidence cases are timed from the observed overflow pulse.

// File: rtl/dual_reload_timer.sv
module dual_reload_timer #(
  parameter int DIV_A = 4,
  parameter int DIV_B = 16,
  parameter int DIV_C = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [3:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       gate0_in,
  input  logic       gate1_in,
  input  logic       ack0,
  input  logic       ack1,
  output logic       irq0,
  output logic       irq1,
  output logic       ovf_pulse0,
  output logic       ovf_pulse1
);
  localparam int PW = $clog2(DIV_C);
  localparam logic [3:0] A_CTRL = 4'd0, A_MODE = 4'd1, A_CFG = 4'd2,
                         A_T0L = 4'd4, A_T0H = 4'd5, A_R0L = 4'd6, A_R0H = 4'd7,
                         A_T1L = 4'd8, A_T1H = 4'd9, A_R1L = 4'd10, A_R1H = 4'd11;

  logic [PW-1:0] pre_cnt;
  logic [PW:0]   div_n;
  logic [1:0]    div_sel, md0, md1;
  logic          toe0, toe1, gt0, gt1, tr0, tr1, tf0, tf1;
  logic [7:0]    l0, h0, rl0, rh0, l1, h1, rl1, rh1;
  logic [15:0]   c0_nx, c1_nx;
  logic          tick, split, en0, en_h0, en1, ovf0, ovf_h0, ovf1, set0, set1, ctrl_wr;

  always_comb
    case (div_sel)
      2'd0:    div_n = (PW+1)'(DIV_A);
      2'd1:    div_n = (PW+1)'(DIV_B);
      default: div_n = (PW+1)'(DIV_C);
    endcase

  assign tick   = ({1'b0, pre_cnt} >= div_n - 1'b1);
  assign split  = (md0 == 2'd3);
  assign en0    = tick & tr0 & (~gt0 | gate0_in);
  assign en_h0  = tick & tr1 & split;
  assign en1    = tick & (md1 != 2'd3) & (split | tr1) & (~gt1 | gate1_in);
  assign ovf0   = en0 & (md0[1] ? (l0 == 8'hFF) : ({h0, l0} == 16'hFFFF));
  assign ovf_h0 = en_h0 & (h0 == 8'hFF);
  assign ovf1   = en1 & (md1[1] ? (l1 == 8'hFF) : ({h1, l1} == 16'hFFFF));
  assign set0   = ovf0 & ~toe0;
  assign set1   = (split ? ovf_h0 : ovf1) & ~toe1;
  assign ctrl_wr = wr_en & (addr == A_CTRL);

  always_comb begin
    c0_nx = {h0, l0};
    if (en0)
      case (md0)
        2'd0:    c0_nx = ovf0 ? {rh0, rl0} : {h0, l0} + 16'd1;
        2'd1:    c0_nx = {h0, l0} + 16'd1;
        2'd2:    c0_nx[7:0] = ovf0 ? rl0 : l0 + 8'd1;
        default: c0_nx[7:0] = l0 + 8'd1;
      endcase
    if (en_h0) c0_nx[15:8] = h0 + 8'd1;
  end

  always_comb begin
    c1_nx = {h1, l1};
    if (en1)
      case (md1)
        2'd0:    c1_nx = ovf1 ? {rh1, rl1} : {h1, l1} + 16'd1;
        2'd1:    c1_nx = {h1, l1} + 16'd1;
        default: c1_nx[7:0] = ovf1 ? rl1 : l1 + 8'd1;
      endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pre_cnt <= '0;
      div_sel <= 2'd0; toe0 <= 1'b0; toe1 <= 1'b0;
      md0 <= 2'd0; md1 <= 2'd0; gt0 <= 1'b0; gt1 <= 1'b0;
      tr0 <= 1'b0; tr1 <= 1'b0; tf0 <= 1'b0; tf1 <= 1'b0;
      l0 <= '0; h0 <= '0; rl0 <= '0; rh0 <= '0;
      l1 <= '0; h1 <= '0; rl1 <= '0; rh1 <= '0;
      ovf_pulse0 <= 1'b0; ovf_pulse1 <= 1'b0;
    end else begin
      pre_cnt <= tick ? '0 : pre_cnt + 1'b1;
      {h0, l0} <= c0_nx;
      {h1, l1} <= c1_nx;
      tf0 <= set0 ? 1'b1 : ack0 ? 1'b0 : ctrl_wr ? wdata[5] : tf0;
      tf1 <= set1 ? 1'b1 : ack1 ? 1'b0 : ctrl_wr ? wdata[7] : tf1;
      ovf_pulse0 <= ovf0;
      ovf_pulse1 <= ovf1;
      if (wr_en)
        case (addr)
          A_CTRL: begin tr0 <= wdata[4]; tr1 <= wdata[6]; end
          A_MODE: begin md0 <= wdata[1:0]; gt0 <= wdata[2]; md1 <= wdata[5:4]; gt1 <= wdata[6]; end
          A_CFG:  begin div_sel <= wdata[1:0]; toe0 <= wdata[2]; toe1 <= wdata[3]; end
          A_T0L:  l0 <= wdata;
          A_T0H:  h0 <= wdata;
          A_R0L:  rl0 <= wdata;
          A_R0H:  rh0 <= wdata;
          A_T1L:  l1 <= wdata;
          A_T1H:  h1 <= wdata;
          A_R1L:  rl1 <= wdata;
          A_R1H:  rh1 <= wdata;
          default: ;
        endcase
    end

  always_comb
    case (addr)
      A_CTRL:  rdata = {tf1, tr1, tf0, tr0, 4'b0};
      A_MODE:  rdata = {1'b0, gt1, md1, 1'b0, gt0, md0};
      A_CFG:   rdata = {4'b0, toe1, toe0, div_sel};
      A_T0L:   rdata = l0;
      A_T0H:   rdata = h0;
      A_R0L:   rdata = rl0;
      A_R0H:   rdata = rh0;
      A_T1L:   rdata = l1;
      A_T1H:   rdata = h1;
      A_R1L:   rdata = rl1;
      A_R1H:   rdata = rh1;
      default: rdata = 8'h00;
    endcase

  assign irq0 = tf0;
  assign irq1 = tf1;
endmodule

// File: rtl/dual_reload_timer_chk.sv
module dual_reload_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [3:0]  addr,
  input logic        ack0,
  input logic        tick,
  input logic        ovf0,
  input logic        set0,
  input logic        tf0,
  input logic        toe0,
  input logic        ovf_pulse0,
  input logic [1:0]  md0,
  input logic [1:0]  md1,
  input logic [7:0]  h0,
  input logic [15:0] c1
);
  p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n) tick |=> !tick);
  p_flag_set_r9: assert property (@(posedge clk) disable iff (!rst_n) set0 |=> tf0);
  p_ack_clear_r9: assert property (@(posedge clk) disable iff (!rst_n) (ack0 && !set0) |=> !tf0);
  p_flag_blocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (toe0 && !tf0 && !(wr_en && addr == 4'd0)) |=> !tf0);
  p_t1_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (md1 == 2'd3 && !(wr_en && (addr == 4'd8 || addr == 4'd9))) |=> $stable(c1));
  p_high_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (md0 == 2'd2 && !(wr_en && addr == 4'd5)) |=> $stable(h0));
  p_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n) ovf0 |=> ovf_pulse0);
endmodule

bind dual_reload_timer dual_reload_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .ack0(ack0),
  .tick(tick), .ovf0(ovf0), .set0(set0), .tf0(tf0), .toe0(toe0),
  .ovf_pulse0(ovf_pulse0), .md0(md0), .md1(md1), .h0(h0), .c1({h1, l1})
);

// File: tb/tb_dual_reload_timer.sv
module tb_dual_reload_timer;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [3:0] addr = 4'd0;
  logic [7:0] wdata = 8'd0;
  logic gate0_in = 1'b0, gate1_in = 1'b0, ack0 = 1'b0, ack1 = 1'b0;
  logic [7:0] rdata;
  logic irq0, irq1, ovf_pulse0, ovf_pulse1;
  int vecs = 0, errs = 0, pc0 = 0, pc1 = 0;
  bit done = 1'b0;

  dual_reload_timer dut (.*);

  always #5 clk = ~clk;
  always @(posedge clk) begin
    if (ovf_pulse0) pc0++;
    if (ovf_pulse1) pc1++;
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_reg(input string req, input logic [3:0] a, input int exp);
    logic [7:0] d;
    rd(a, d);
    chk(req, $sformatf("addr %0d", a), d, exp);
  endtask

  task automatic run(input logic [7:0] on, input int clocks);
    logic [7:0] d;
    wr(4'd0, on);
    repeat (clocks - 1) @(negedge clk);
    rd(4'd0, d);
    wr(4'd0, d & 8'hA0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      errs++; vecs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int a = 0; a < 12; a++) chk_reg("R1", 4'(a), 0);
    chk("R1", "irq", {irq1, irq0}, 0);
    chk("R1", "pulses", {ovf_pulse1, ovf_pulse0}, 0);
    wr(4'd1, 8'h01);
    run(8'h10, 4 * 6);
    chk_reg("R1", 4'd4, 6);

    for (int a = 4; a < 12; a++) begin
      wr(4'(a), 8'(a * 8'h11 + 1));
      chk_reg("R13", 4'(a), a * 8'h11 + 1);
    end
    wr(4'd1, 8'h77); chk_reg("R13", 4'd1, 8'h77);
    wr(4'd2, 8'h0F); chk_reg("R13", 4'd2, 8'h0F);
    wr(4'd3, 8'hAA); chk_reg("R13", 4'd3, 0);
    wr(4'd1, 8'h00); wr(4'd2, 8'h00);

    wr(4'd0, 8'hAF); chk_reg("R8", 4'd0, 8'hA0);
    ack1 = 1'b1; @(negedge clk); ack1 = 1'b0;
    chk_reg("R8", 4'd0, 8'h20);
    chk("R9", "ack1 clear irq", {irq1, irq0}, 1);
    ack0 = 1'b1; @(negedge clk); ack0 = 1'b0;
    chk_reg("R9", 4'd0, 8'h00);
    wr(4'd0, 8'h20); wr(4'd0, 8'h00);
    chk_reg("R9", 4'd0, 8'h00);

    for (int s = 0; s < 4; s++) begin
      int n;
      n = (s == 0) ? 4 : (s == 1) ? 16 : 64;
      wr(4'd2, 8'(s));
      repeat (70) @(negedge clk);
      wr(4'd1, 8'h01); wr(4'd4, 8'h00); wr(4'd5, 8'h00);
      run(8'h10, 5 * n);
      chk_reg("R2", 4'd4, 5);
      chk_reg("R2", 4'd5, 0);
    end
    wr(4'd2, 8'h00);
    repeat (70) @(negedge clk);

    for (int t = 0; t < 2; t++)
      for (int md = 0; md < 3; md++)
        for (int ri = 0; ri < 4; ri++)
          for (int k = 1; k <= 12; k++) begin
            int base, v, nov, rl, start, r16;
            string rq;
            base = t ? 8 : 4;
            rl = (ri == 0) ? 8'hF0 : (ri == 1) ? 8'hFA : (ri == 2) ? 8'hFE : 8'hFF;
            rq = (md == 0) ? "R3" : (md == 1) ? "R4" : "R5";
            wr(4'd0, 8'h00);
            wr(4'd1, t ? 8'(md << 4) : 8'(md));
            start = (md == 2) ? 16'h5AF8 : 16'hFFF8;
            r16 = (md == 2) ? (16'h3300 | rl) : (16'hFF00 | rl);
            wr(4'(base), 8'(start)); wr(4'(base + 1), 8'(start >> 8));
            wr(4'(base + 2), 8'(r16)); wr(4'(base + 3), 8'(r16 >> 8));
            p = t ? pc1 : pc0;
            run(t ? 8'h40 : 8'h10, 4 * k);
            v = start; nov = 0;
            for (int i = 0; i < k; i++) begin
              if (md == 2) begin
                if ((v & 255) == 255) begin v = (v & 16'hFF00) | rl; nov++; end
                else v++;
              end else if (v == 16'hFFFF) begin
                v = (md == 0) ? r16 : 0; nov++;
              end else v++;
            end
            chk_reg(rq, 4'(base), v & 255);
            chk_reg(rq, 4'(base + 1), v >> 8);
            rd(4'd0, d);
            chk(rq, "flag", t ? d[7] : d[5], nov > 0);
            chk("R11", "pulse count", (t ? pc1 : pc0) - p, nov);
          end
    wr(4'd0, 8'h00);

    wr(4'd1, 8'h30); wr(4'd8, 8'h34); wr(4'd9, 8'h12);
    p = pc1;
    run(8'h40, 4 * 10);
    chk_reg("R6", 4'd8, 8'h34);
    chk_reg("R6", 4'd9, 8'h12);
    chk("R6", "pulse count", pc1 - p, 0);
    chk_reg("R6", 4'd0, 8'h00);

    wr(4'd1, 8'h33); wr(4'd4, 8'hFE); wr(4'd5, 8'hFD);
    p = pc0;
    run(8'h50, 4 * 3);
    chk_reg("R7", 4'd4, 8'h01);
    chk_reg("R7", 4'd5, 8'h00);
    chk_reg("R7", 4'd0, 8'hA0);
    chk("R7", "pulse0 count", pc0 - p, 1);
    wr(4'd0, 8'h00);
    wr(4'd4, 8'h10); wr(4'd5, 8'h20);
    run(8'h40, 4 * 5);
    chk_reg("R7", 4'd4, 8'h10);
    chk_reg("R7", 4'd5, 8'h25);

    wr(4'd0, 8'h00); wr(4'd8, 8'hFE); wr(4'd9, 8'hFF);
    p = pc1;
    wr(4'd1, 8'h13);
    repeat (4 * 3 - 1) @(negedge clk);
    wr(4'd1, 8'h33);
    repeat (2) @(negedge clk);
    chk_reg("R11", 4'd8, 8'h01);
    chk_reg("R11", 4'd9, 8'h00);
    chk("R11", "split pulse1 count", pc1 - p, 1);
    chk_reg("R11", 4'd0, 8'h00);

    wr(4'd1, 8'h01); wr(4'd2, 8'h04); wr(4'd4, 8'hFE); wr(4'd5, 8'hFF);
    p = pc0;
    run(8'h10, 4 * 3);
    chk_reg("R10", 4'd4, 8'h01);
    chk_reg("R10", 4'd0, 8'h00);
    chk("R10", "pulse still", pc0 - p, 1);
    wr(4'd2, 8'h00);

    wr(4'd1, 8'h05); wr(4'd4, 8'h00); wr(4'd5, 8'h00);
    gate0_in = 1'b0;
    run(8'h10, 4 * 8);
    chk_reg("R12", 4'd4, 0);
    gate0_in = 1'b1;
    run(8'h10, 4 * 8);
    chk_reg("R12", 4'd4, 8);
    gate0_in = 1'b0;

    wr(4'd1, 8'h02); wr(4'd4, 8'hFD); wr(4'd6, 8'hF0); wr(4'd0, 8'h00);
    ack0 = 1'b1;
    wr(4'd0, 8'h10);
    for (int i = 0; i < 200 && !ovf_pulse0; i++) @(negedge clk);
    ack0 = 1'b0;
    chk("R9", "overflow beats ack", irq0, 1);
    wr(4'd0, 8'h00);
    wr(4'd4, 8'hFD);
    wr_en = 1'b1; addr = 4'd0; wdata = 8'h10;
    for (int i = 0; i < 200 && !ovf_pulse0; i++) @(negedge clk);
    wr_en = 1'b0;
    chk("R9", "overflow beats write 0", irq0, 1);
    wr(4'd0, 8'h00);
    chk("R9", "write 0 clears", irq0, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule